// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Request Latch

This block is the capture stage in front of an interrupt priority resolver. It watches eight request lines and keeps one pending bit per line. Each line senses either levels or rising edges, and a per-line trigger-mode register picks which. A level-sensed line's pending bit follows the line. An edge-sensed line's pending bit is set by a low-to-high transition and then stays set until it is cleared.

The downstream controller clears pending bits with two kinds of one-cycle pulse. An acknowledge pulse clears only an edge-sensed request, because a level request stays valid for as long as its line is held. A poll pulse clears the selected bit whatever its mode. An initialization pulse wipes the pending bits and the remembered line levels but keeps the trigger modes. Software writes and reads the trigger-mode register through a byte-wide port. The write is filtered by a constant writable-bit mask, so lines that are tied to edge sensing cannot be switched to level sensing.

Top module: `irq_capture_latch`

## Requirements
- R1: When rst_n is low at a clock edge, pend_o, mode_o and mode_rdata are all zero after that edge.
- R2: For a line whose mode_o bit is 1 (level sensing), pend_o for that line after an edge equals irq_in for that line at the edge, unless a poll for that line or init_clr is applied at the same edge.
- R3: For a line whose mode_o bit is 0 (edge sensing), pend_o sets at an edge where irq_in is 1 and the line's value at the previous sampled edge was 0. After init_clr, the previous value counts as 0.
- R4: For an edge-sensed line, a low irq_in never clears a captured pending bit.
- R5: An acknowledge (ack_valid=1, ack_sel=n) clears pend_o[n] at that edge only when line n is edge-sensed. A level-sensed pending bit is unaffected.
- R6: A poll (poll_valid=1, poll_sel=n) clears pend_o[n] at that edge whatever the mode. A level-sensed line that is still high sets again at the following edge.
- R7: mode_wr stores mode_wdata AND MODE_WMASK (default 8'hF8, so bits 2..0 always read 0) into mode_o. mode_rdata returns the stored value. A 1 in bit n selects level sensing for line n.
- R8: init_clr clears pend_o and the remembered line levels at that edge and leaves mode_o unchanged. An edge-sensed line that is held high is captured again at the next edge.
- R9: When a rising edge and a clear for the same edge-sensed line come at the same edge, the new request wins and pend_o stays 1.
- R10: An edge-sensed line held high produces only one capture. Repeated acknowledges while it stays high leave pend_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_clr | input | 1 | Initialization pulse: clears pending and remembered levels |
| irq_in | input | NUM_LINES | Request lines, sampled on every rising clock edge |
| ack_valid | input | 1 | Acknowledge clear pulse |
| ack_sel | input | SEL_W | Line index for the acknowledge |
| poll_valid | input | 1 | Poll clear pulse |
| poll_sel | input | SEL_W | Line index for the poll |
| mode_wr | input | 1 | Trigger-mode register write strobe |
| mode_wdata | input | REG_W | Trigger-mode write data |
| mode_rdata | output | REG_W | Trigger-mode register read value |
| pend_o | output | NUM_LINES | Pending request vector |
| mode_o | output | NUM_LINES | Trigger-mode vector (1 = level) |

## Verification
The two functions that can meet in one cycle are capture and clear. A rising edge on an edge-sensed line can arrive at the same edge as an acknowledge or a poll for that line. A poll can also fall on a level-sensed line that is still high. The bench raises line 0 in the same cycle as its acknowledge and expects the bit to stay pending. It then polls a held-high level line and expects one cleared cycle before the bit sets again. A mode write that takes effect while a level line is pending is also checked, to confirm that the old mode governs that edge.

// File: rtl/irq_latch_pkg.sv
// Package: shared encodings for the interrupt request latch.
// Assumes: one mode bit per request line.
package irq_latch_pkg;
    // Encoding of one trigger-mode bit
    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;
endpackage

// File: rtl/irq_mode_reg.sv
// Trigger-mode register. It holds one mode bit per line.
// Writes are ANDed with the constant WMASK, so masked bits stay 0.
// It is not touched by the initialization pulse, only by rst_n.
module irq_mode_reg #(
    parameter int              NUM_LINES = 8,
    parameter int              REG_W     = 8,
    parameter logic [NUM_LINES-1:0] WMASK = 8'hF8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wdata,
    output logic [NUM_LINES-1:0] mode_q,
    output logic [REG_W-1:0]     rdata
);
    localparam int USED_W = (NUM_LINES < REG_W) ? NUM_LINES : REG_W;

    logic [NUM_LINES-1:0] wr_val;

    // Widen or trim write data to the line count
    always_comb begin
        wr_val = '0;
        wr_val[USED_W-1:0] = wdata[USED_W-1:0];
    end

    // Store masked write data
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (wr_en)
            mode_q <= wr_val & WMASK;
    end

    // Present the stored mode on the byte read port
    always_comb begin
        rdata = '0;
        rdata[USED_W-1:0] = mode_q[USED_W-1:0];
    end
endmodule

// File: rtl/irq_clear_decode.sv
// Clear-pulse decoder. It turns the acknowledge and poll indices into
// one-hot per-line hit vectors. An index beyond the line count hits nothing.
module irq_clear_decode #(
    parameter int NUM_LINES = 8,
    parameter int SEL_W     = 3
) (
    input  logic                 ack_valid,
    input  logic [SEL_W-1:0]     ack_sel,
    input  logic                 poll_valid,
    input  logic [SEL_W-1:0]     poll_sel,
    output logic [NUM_LINES-1:0] ack_hit,
    output logic [NUM_LINES-1:0] poll_hit
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_dec
        // Compare each index against this line number
        always_comb begin
            ack_hit[i]  = ack_valid  && (ack_sel  == SEL_W'(i));
            poll_hit[i] = poll_valid && (poll_sel == SEL_W'(i));
        end
    end
endmodule

// File: rtl/irq_line_cell.sv
// Capture cell for one request line.
// It holds the pending bit and the last sampled level of the line.
// Level mode: pending follows the line, and a poll blanks it for one cycle.
// Edge mode: a rise sets pending. An acknowledge or poll clears it,
// but a rise at the same edge wins.
// Assumes line_in is already synchronous to clk.
module irq_line_cell
    import irq_latch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic init_clr,
    input  logic line_in,
    input  logic level_mode,
    input  logic ack_hit,
    input  logic poll_hit,
    output logic pend_q
);
    logic last_q;
    logic rise;
    logic pend_d;

    // Detect a low-to-high change against the previous sample
    always_comb rise = line_in && !last_q;

    // Next pending value for the selected trigger mode
    always_comb begin
        if (trig_mode_e'(level_mode) == TRIG_LEVEL)
            pend_d = line_in && !poll_hit;
        else
            pend_d = rise || (pend_q && !(ack_hit || poll_hit));
    end

    // Pending and last-level registers
    always_ff @(posedge clk) begin
        if (!rst_n || init_clr) begin
            pend_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
            last_q <= line_in;
        end
    end
endmodule

// File: rtl/irq_capture_latch.sv
// Top of the interrupt request latch. It joins the trigger-mode register,
// the clear decoder and one capture cell per line.
// Assumes irq_in is synchronous and that clears are single-cycle pulses.
module irq_capture_latch #(
    parameter int                   NUM_LINES  = 8,
    parameter int                   REG_W      = 8,
    parameter logic [NUM_LINES-1:0] MODE_WMASK = 8'hF8,
    localparam int                  SEL_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 init_clr,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 ack_valid,
    input  logic [SEL_W-1:0]     ack_sel,
    input  logic                 poll_valid,
    input  logic [SEL_W-1:0]     poll_sel,
    input  logic                 mode_wr,
    input  logic [REG_W-1:0]     mode_wdata,
    output logic [REG_W-1:0]     mode_rdata,
    output logic [NUM_LINES-1:0] pend_o,
    output logic [NUM_LINES-1:0] mode_o
);
    logic [NUM_LINES-1:0] ack_hit;
    logic [NUM_LINES-1:0] poll_hit;

    irq_mode_reg #(
        .NUM_LINES (NUM_LINES),
        .REG_W     (REG_W),
        .WMASK     (MODE_WMASK)
    ) mode_reg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (mode_wr),
        .wdata  (mode_wdata),
        .mode_q (mode_o),
        .rdata  (mode_rdata)
    );

    irq_clear_decode #(
        .NUM_LINES (NUM_LINES),
        .SEL_W     (SEL_W)
    ) clr_dec_i (
        .ack_valid  (ack_valid),
        .ack_sel    (ack_sel),
        .poll_valid (poll_valid),
        .poll_sel   (poll_sel),
        .ack_hit    (ack_hit),
        .poll_hit   (poll_hit)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        irq_line_cell cell_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .init_clr   (init_clr),
            .line_in    (irq_in[i]),
            .level_mode (mode_o[i]),
            .ack_hit    (ack_hit[i]),
            .poll_hit   (poll_hit[i]),
            .pend_q     (pend_o[i])
        );
    end
endmodule

// File: rtl/irq_capture_latch_chk.sv
// Checker for irq_capture_latch. It sees only the top-level ports and
// is bound to every instance of the top.
module irq_capture_latch_chk #(
    parameter int                   NUM_LINES  = 8,
    parameter int                   REG_W      = 8,
    parameter logic [NUM_LINES-1:0] MODE_WMASK = 8'hF8,
    parameter int                   SEL_W      = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 init_clr,
    input logic [NUM_LINES-1:0] irq_in,
    input logic                 ack_valid,
    input logic [SEL_W-1:0]     ack_sel,
    input logic                 poll_valid,
    input logic [SEL_W-1:0]     poll_sel,
    input logic                 mode_wr,
    input logic [REG_W-1:0]     mode_wdata,
    input logic [REG_W-1:0]     mode_rdata,
    input logic [NUM_LINES-1:0] pend_o,
    input logic [NUM_LINES-1:0] mode_o
);
    logic [1:0] up_cnt;

    // Count cycles out of reset, so that $past only looks at post-reset samples
    always_ff @(posedge clk) begin
        if (!rst_n)
            up_cnt <= '0;
        else if (up_cnt != 2'd3)
            up_cnt <= up_cnt + 2'd1;
    end

    wire past_ok  = (up_cnt != 2'd0);
    wire past2_ok = (up_cnt >= 2'd2);

    AST_MODE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(mode_wr)) |-> mode_o == ($past(mode_wdata[NUM_LINES-1:0]) & MODE_WMASK)); // R7
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(!mode_wr)) |-> mode_o == $past(mode_o)); // R8
    AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(init_clr)) |-> pend_o == '0); // R8
    AST_READ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        mode_rdata[NUM_LINES-1:0] == mode_o); // R7

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
        wire ack_i  = ack_valid  && (ack_sel  == SEL_W'(i));
        wire poll_i = poll_valid && (poll_sel == SEL_W'(i));

        AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $past(mode_o[i] && !init_clr && !poll_i)) |-> pend_o[i] == $past(irq_in[i])); // R2
        AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (past2_ok && $past(!mode_o[i] && !init_clr && irq_in[i]) && !$past(irq_in[i], 2)) |-> pend_o[i]); // R3
        AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $past(!mode_o[i] && pend_o[i] && !init_clr && !ack_i && !poll_i)) |-> pend_o[i]); // R4
        AST_ACK_SPARES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $past(mode_o[i] && irq_in[i] && ack_i && !poll_i && !init_clr)) |-> pend_o[i]); // R5
        AST_POLL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $past(poll_i && !init_clr && (mode_o[i] || !irq_in[i]))) |-> !pend_o[i]); // R6
    end
endmodule

bind irq_capture_latch irq_capture_latch_chk #(
    .NUM_LINES  (NUM_LINES),
    .REG_W      (REG_W),
    .MODE_WMASK (MODE_WMASK),
    .SEL_W      (SEL_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_clr   (init_clr),
    .irq_in     (irq_in),
    .ack_valid  (ack_valid),
    .ack_sel    (ack_sel),
    .poll_valid (poll_valid),
    .poll_sel   (poll_sel),
    .mode_wr    (mode_wr),
    .mode_wdata (mode_wdata),
    .mode_rdata (mode_rdata),
    .pend_o     (pend_o),
    .mode_o     (mode_o)
);

// File: tb/irq_capture_latch_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench. A driver task applies one cycle of stimulus on the
// falling edge and queues the outputs expected after the next rising edge.
// A monitor compares them on the falling edge of the cycle they fall due.
module irq_capture_latch_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_clr = 1'b0;
    logic [7:0] irq_in = '0;
    logic       ack_valid = 1'b0;
    logic [2:0] ack_sel = '0;
    logic       poll_valid = 1'b0;
    logic [2:0] poll_sel = '0;
    logic       mode_wr = 1'b0;
    logic [7:0] mode_wdata = '0;
    logic [7:0] mode_rdata;
    logic [7:0] pend_o;
    logic [7:0] mode_o;

    typedef struct {
        int         due;
        logic [7:0] pend;
        logic [7:0] mode;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;

    always #2.5 clk = ~clk;

    irq_capture_latch dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_clr   (init_clr),
        .irq_in     (irq_in),
        .ack_valid  (ack_valid),
        .ack_sel    (ack_sel),
        .poll_valid (poll_valid),
        .poll_sel   (poll_sel),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .mode_rdata (mode_rdata),
        .pend_o     (pend_o),
        .mode_o     (mode_o)
    );

    // Count rising edges, which gives the due time for queued items
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop items that fall due and compare them with the outputs
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            total++;
            if (pend_o !== e.pend || mode_o !== e.mode || mode_rdata !== e.mode) begin
                bad++;
                $display("FAIL %s: pend=%h mode=%h rdata=%h expected pend=%h mode=%h rdata=%h",
                         e.tag, pend_o, mode_o, mode_rdata, e.pend, e.mode, e.mode);
            end
        end
    end

    // Driver: one cycle of stimulus plus the outputs expected after it
    task automatic step(input logic [7:0] lines, input bit a_v, input int a_l,
                        input bit p_v, input int p_l, input bit wr, input logic [7:0] wd,
                        input bit ini, input logic [7:0] e_pend, input logic [7:0] e_mode,
                        input string tag);
        @(negedge clk);
        irq_in     = lines;
        ack_valid  = a_v;
        ack_sel    = 3'(a_l);
        poll_valid = p_v;
        poll_sel   = 3'(p_l);
        mode_wr    = wr;
        mode_wdata = wd;
        init_clr   = ini;
        exp_q.push_back('{cyc + 1, e_pend, e_mode, tag});
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            bad++;
            $display("FAIL watchdog: state=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        //    lines  ack    poll   wr  wdata  ini pend   mode
        step(8'h00, 0, 0, 0, 0, 0, 8'h00, 0, 8'h00, 8'h00, "R1 reset state");
        step(8'h00, 0, 0, 0, 0, 1, 8'hFF, 0, 8'h00, 8'hF8, "R7 masked write");
        step(8'h01, 0, 0, 0, 0, 0, 8'h00, 0, 8'h01, 8'hF8, "R3 edge capture");
        step(8'h01, 0, 0, 0, 0, 0, 8'h00, 0, 8'h01, 8'hF8, "R3 held high");
        step(8'h00, 0, 0, 0, 0, 0, 8'h00, 0, 8'h01, 8'hF8, "R4 low keeps edge pending");
        step(8'h01, 1, 0, 0, 0, 0, 8'h00, 0, 8'h01, 8'hF8, "R9 rise beats ack");
        step(8'h01, 1, 0, 0, 0, 0, 8'h00, 0, 8'h00, 8'hF8, "R5 ack clears edge");
        step(8'h01, 1, 0, 0, 0, 0, 8'h00, 0, 8'h00, 8'hF8, "R10 repeat ack no recapture");
        step(8'h01, 0, 0, 0, 0, 0, 8'h00, 0, 8'h00, 8'hF8, "R10 held line idle");
        step(8'h09, 0, 0, 0, 0, 0, 8'h00, 0, 8'h08, 8'hF8, "R2 level follows high");
        step(8'h09, 1, 3, 0, 0, 0, 8'h00, 0, 8'h08, 8'hF8, "R5 ack spares level");
        step(8'h09, 0, 0, 1, 3, 0, 8'h00, 0, 8'h00, 8'hF8, "R6 poll clears level");
        step(8'h09, 0, 0, 0, 0, 0, 8'h00, 0, 8'h08, 8'hF8, "R6 level sets again");
        step(8'h01, 0, 0, 0, 0, 0, 8'h00, 0, 8'h00, 8'hF8, "R2 level follows low");
        step(8'h05, 0, 0, 0, 0, 0, 8'h00, 0, 8'h04, 8'hF8, "R3 second edge line");
        step(8'h05, 0, 0, 1, 2, 0, 8'h00, 0, 8'h00, 8'hF8, "R6 poll clears edge");
        step(8'h25, 0, 0, 0, 0, 0, 8'h00, 0, 8'h20, 8'hF8, "R2 level line 5");
        step(8'h25, 0, 0, 0, 0, 0, 8'h00, 1, 8'h00, 8'hF8, "R8 init clears pending keeps mode");
        step(8'h25, 0, 0, 0, 0, 0, 8'h00, 0, 8'h25, 8'hF8, "R8 recapture after init");
        step(8'h25, 0, 0, 0, 0, 1, 8'h00, 0, 8'h25, 8'h00, "R7 mode write old mode governs edge");
        step(8'h05, 0, 0, 0, 0, 0, 8'h00, 0, 8'h25, 8'h00, "R4 now-edge line keeps pending");
        step(8'h05, 0, 0, 0, 0, 1, 8'h07, 0, 8'h25, 8'h00, "R7 masked bits stay zero");
        step(8'h05, 1, 5, 0, 0, 0, 8'h00, 0, 8'h05, 8'h00, "R5 ack clears line 5");
        step(8'h05, 1, 0, 0, 0, 0, 8'h00, 0, 8'h04, 8'h00, "R10 ack held line 0");
        step(8'h05, 0, 0, 0, 0, 0, 8'h00, 0, 8'h04, 8'h00, "R10 no second capture");
        @(negedge clk);
        irq_in = '0; ack_valid = 1'b0; poll_valid = 1'b0; mode_wr = 1'b0; init_clr = 1'b0;
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule